// File: doc/BRIEF.md
# Programmable Tausworthe PN Ranging Chip Generator

This block produces a composite ranging chip stream for a regenerative ranging channel. It does not use one long shift register. It runs six short periodic component sequences side by side and combines them chip by chip with a vote. The components are a two-chip range clock and five pseudo-noise sequences. Their lengths are 2, 7, 11, 15, 19 and 23 chips. These lengths share no common factor, so the composite repeats only after 1,009,470 chips, while each component stays small enough to hold as a constant pattern.

A scheme select chooses how the components are combined:
- the plain rule, in which the clock chip dominates unless all five PN chips agree;
- a weighted vote that gives the clock a weight of 2;
- a weighted vote that gives the clock a weight of 4.

A balance control negates three of the PN components, which reduces the DC content of the composite.

Each component chip, with any balance inversion applied, is also driven out, so correlators can use the generator as their local replica. All phases advance together, one chip per chip-enable strobe. A synchronous initialise strobe returns every component to its first chip. This lets a transmit instance and a receive instance be aligned.

Top module: `tpn_ranging_gen`

## Requirements
- R1: When reset is released, every component stands at the first chip of its pattern. With balance off, `comp_chip_o` reads 6'b000000 and `range_chip_o` reads 0.
- R2: Each chip-enable cycle advances every component by one chip. Component k (bit k-1 of `comp_chip_o`) steps through its pattern and wraps after its length. All chip outputs encode +1 as logic 0 and -1 as logic 1. The patterns are:
  - C1 (length 2): `+-`
  - C2 (length 7): `+++--+-`
  - C3 (length 11): `+++---+-++-`
  - C4 (length 15): `++++---+--++-+-`
  - C5 (length 19): `++++-+-+----++-++--`
  - C6 (length 23): `+++++-+-++--++--+-+----`
- R3: When neither chip enable nor initialise is asserted, the component phases and all outputs hold their values.
- R4: Asserting the initialise strobe sets every component to its first chip in the next cycle. Initialise takes priority over a chip enable asserted in the same cycle.
- R5: With `mode_i` = 2'b00 (plain rule), the ranging chip is +1 exactly when C1 is +1 or when C2 to C6 are all +1.
- R6: With `mode_i` = 2'b01, the ranging chip is the sign of 2·C1 + C2 + C3 + C4 + C5 + C6.
- R7: With `mode_i` = 2'b10, the ranging chip is the sign of 4·C1 + C2 + C3 + C4 + C5 + C6.
- R8: The value `mode_i` = 2'b11 behaves as the plain rule of R5.
- R9: With `balance_i` = 1, C3, C4 and C6 are negated. The negation applies both to the vote and to bits 2, 3 and 5 of `comp_chip_o`. Changing `balance_i` takes effect at once and does not move any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_i | input | 1 | Advance all components by one chip |
| init_i | input | 1 | Synchronous return of all components to their first chip |
| mode_i | input | 2 | Combining scheme: 00 plain, 01 clock weight 2, 10 clock weight 4, 11 plain |
| balance_i | input | 1 | Negate C3, C4 and C6 |
| range_chip_o | output | 1 | Composite ranging chip (0 = +1, 1 = -1) |
| comp_chip_o | output | 6 | Component chips, bit 0 = C1 through bit 5 = C6, balance applied |

## Verification
The bench builds the block with its default weights of 2 and 4 and the six fixed component lengths. Runs of 500 chips are made in every scheme, both with balance off and with balance on. Each run wraps C6 more than twenty times and visits every phase pairing of C1 and C6. It also reaches the rare all-minus and all-plus PN windows, in which the plain rule and the weight-2 vote part from the clock. The full composite period is far too long to reach, so the wrap at the composite period is covered through the component wraps alone.

// File: rtl/tpn_pkg.sv
// Package: shared constants and types of the Tausworthe ranging generator.
// Patterns are stored with bit n holding chip n of the first period,
// encoded 0 for +1 and 1 for -1.
package tpn_pkg;

    localparam int NUM_COMP = 6;
    localparam int MAX_LEN  = 23;

    typedef logic [MAX_LEN-1:0] pat_t;

    localparam int COMP_LEN [NUM_COMP] = '{2, 7, 11, 15, 19, 23};

    localparam pat_t COMP_PAT [NUM_COMP] = '{
        23'(2'b10),
        23'(7'b1011000),
        23'(11'b10010111000),
        23'(15'b101001101110000),
        23'(19'b1100100111101010000),
        23'b11110101100110010100000
    };

    // Components negated in the balanced variant (C3, C4, C6).
    localparam logic [NUM_COMP-1:0] BAL_MASK = 6'b101100;

    localparam int CLK_WEIGHT_LO = 2;
    localparam int CLK_WEIGHT_HI = 4;

    typedef enum logic [1:0] {
        SCH_PLAIN = 2'b00,
        SCH_WLO   = 2'b01,
        SCH_WHI   = 2'b10,
        SCH_RSVD  = 2'b11
    } scheme_e;

endpackage

// File: rtl/tpn_component.sv
// Module: one periodic component generator.
// Holds a modulo-LEN phase counter and reads the chip from a constant
// pattern. Assumes PAT bit n is chip n (0 = +1). Initialise wins over advance.
module tpn_component #(
    parameter int             LEN = 7,
    parameter logic [LEN-1:0] PAT = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic init_i,
    input  logic invert_i,
    output logic chip_o
);
    localparam int PW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(LEN - 1);

    logic [PW-1:0] phase_q;

    // Phase counter: reset/initialise to zero, wrap after the last chip.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            phase_q <= '0;
        end else if (adv_i) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    // Pattern lookup with optional polarity inversion.
    always_comb begin
        chip_o = PAT[phase_q] ^ invert_i;
    end
endmodule

// File: rtl/tpn_vote.sv
// Module: combining logic of the component chips.
// Plain rule for schemes 00 and 11; weighted sign for 01 and 10.
// Assumes the weighted total (weight + NUM-1) is odd, so no tie occurs.
module tpn_vote #(
    parameter int NUM  = 6,
    parameter int W_LO = 2,
    parameter int W_HI = 4
) (
    input  logic [NUM-1:0] chips_i,
    input  logic [1:0]     scheme_i,
    output logic           chip_o
);
    import tpn_pkg::*;

    localparam int CW = $clog2(2 * (W_HI + NUM) + 1);

    logic          plain_chip;
    logic          wtd_chip;
    logic [CW-1:0] weight;
    logic [CW-1:0] plus_w;

    // Plain rule: -1 only when the clock is -1 and some PN chip is -1.
    always_comb begin
        plain_chip = chips_i[0] & (|chips_i[NUM-1:1]);
    end

    // Weighted vote: compare the +1 weight against half the total weight.
    always_comb begin
        weight = (scheme_i == SCH_WHI) ? CW'(W_HI) : CW'(W_LO);
        plus_w = chips_i[0] ? '0 : weight;
        for (int k = 1; k < NUM; k++) begin
            plus_w = plus_w + CW'(!chips_i[k]);
        end
        wtd_chip = !((plus_w << 1) > (weight + CW'(NUM - 1)));
    end

    // Scheme select.
    always_comb begin
        chip_o = (scheme_i == SCH_WLO || scheme_i == SCH_WHI) ? wtd_chip : plain_chip;
    end
endmodule

// File: rtl/tpn_ranging_gen.sv
// Module: top of the programmable Tausworthe PN ranging generator.
// Instantiates one generator per component and the vote. All phases share
// the chip enable and the initialise strobe. Outputs are combinational
// from the phase registers.
module tpn_ranging_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en_i,
    input  logic       init_i,
    input  logic [1:0] mode_i,
    input  logic       balance_i,
    output logic       range_chip_o,
    output logic [5:0] comp_chip_o
);
    import tpn_pkg::*;

    logic [NUM_COMP-1:0] chips;

    for (genvar i = 0; i < NUM_COMP; i++) begin : g_comp
        localparam int L = COMP_LEN[i];
        tpn_component #(
            .LEN (L),
            .PAT (COMP_PAT[i][L-1:0])
        ) u_comp (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv_i    (chip_en_i),
            .init_i   (init_i),
            .invert_i (balance_i & BAL_MASK[i]),
            .chip_o   (chips[i])
        );
    end

    tpn_vote #(
        .NUM  (NUM_COMP),
        .W_LO (CLK_WEIGHT_LO),
        .W_HI (CLK_WEIGHT_HI)
    ) u_vote (
        .chips_i  (chips),
        .scheme_i (mode_i),
        .chip_o   (range_chip_o)
    );

    // Drive the component taps for the correlators.
    always_comb begin
        comp_chip_o = chips;
    end
endmodule

// File: rtl/tpn_ranging_chk.sv
// Module: assertion checker for tpn_ranging_gen, attached by bind.
module tpn_ranging_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_en_i,
    input logic       init_i,
    input logic [1:0] mode_i,
    input logic       balance_i,
    input logic       range_chip_o,
    input logic [5:0] comp_chip_o
);
    // R2: the range clock alternates on every advance.
    a_r2_clock_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_i && !init_i) |=> (comp_chip_o[0] != $past(comp_chip_o[0])));

    // R3: with no strobe the range clock holds.
    a_r3_clock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_i && !init_i) |=> $stable(comp_chip_o[0]));

    // R4: initialise brings all components to their first chip.
    a_r4_init_phase: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (comp_chip_o == ({6{balance_i}} & 6'b101100)));

    // R5: in the plain rule a +1 clock chip forces a +1 output.
    a_r5_plain_clock_plus: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && !comp_chip_o[0]) |-> !range_chip_o);

    // R6: with weight 2, five PN chips against the clock outvote it.
    a_r6_wlo_unanimous: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && comp_chip_o[5:1] == {5{~comp_chip_o[0]}})
        |-> (range_chip_o != comp_chip_o[0]));

    // R7: with weight 4, the clock wins unless all PN chips oppose it.
    a_r7_whi_clock_rules: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && comp_chip_o[5:1] != {5{~comp_chip_o[0]}})
        |-> (range_chip_o == comp_chip_o[0]));
endmodule

bind tpn_ranging_gen tpn_ranging_chk u_chk (.*);

// File: tb/tpn_ranging_gen_bench.sv
// Bench: directed scenarios against a string-based model of the sequences.
module tpn_ranging_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en_i = 1'b0;
    logic       init_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       balance_i = 1'b0;
    logic       range_chip_o;
    logic [5:0] comp_chip_o;

    int vectors = 0;
    int errors = 0;
    int n = 0;
    logic finished = 1'b0;

    string seqs [6] = '{"+-", "+++--+-", "+++---+-++-", "++++---+--++-+-",
                        "++++-+-+----++-++--", "+++++-+-++--++--+-+----"};
    logic [5:0] bal_mask = 6'b101100;

    tpn_ranging_gen u_tpn_ranging_gen (
        .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en_i), .init_i(init_i),
        .mode_i(mode_i), .balance_i(balance_i),
        .range_chip_o(range_chip_o), .comp_chip_o(comp_chip_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] exp_comp(int idx, logic bal);
        logic [5:0] c;
        for (int i = 0; i < 6; i++) begin
            c[i] = (seqs[i][idx % seqs[i].len()] == "-");
            if (bal && bal_mask[i]) c[i] = ~c[i];
        end
        return c;
    endfunction

    function automatic logic exp_range(logic [5:0] c, logic [1:0] m);
        int s;
        int v;
        if (m == 2'b01 || m == 2'b10) begin
            v = (m == 2'b01) ? 2 : 4;
            s = c[0] ? -v : v;
            for (int i = 1; i < 6; i++) s += c[i] ? -1 : 1;
            return s < 0;
        end
        return c[0] && (c[5:1] != 5'b0);
    endfunction

    task automatic check(string req);
        logic [5:0] ec;
        logic er;
        ec = exp_comp(n, balance_i);
        er = exp_range(ec, mode_i);
        vectors++;
        if (comp_chip_o !== ec || range_chip_o !== er) begin
            errors++;
            $display("FAIL %s chip %0d: comp=%b range=%b expected comp=%b range=%b",
                     req, n, comp_chip_o, range_chip_o, ec, er);
        end
    endtask

    // One clock with the given strobes; the model follows R2/R4.
    task automatic tick(logic en, logic ini);
        chip_en_i = en;
        init_i = ini;
        @(negedge clk);
        if (ini) n = 0;
        else if (en) n++;
        chip_en_i = 1'b0;
        init_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1");
    endtask

    task automatic t_scheme(logic [1:0] m, logic b, int count, string req);
        mode_i = m;
        balance_i = b;
        tick(1'b0, 1'b1);
        check(req);
        for (int k = 0; k < count; k++) begin
            tick(1'b1, 1'b0);
            check(req);
        end
    endtask

    task automatic t_hold();
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            tick(1'b0, 1'b0);
            check("R3");
        end
    endtask

    task automatic t_init();
        for (int k = 0; k < 37; k++) tick(1'b1, 1'b0);
        tick(1'b1, 1'b1);
        check("R4");
        tick(1'b1, 1'b0);
        check("R4");
    endtask

    task automatic t_balance_switch();
        mode_i = 2'b01;
        for (int k = 0; k < 13; k++) tick(1'b1, 1'b0);
        balance_i = 1'b1;
        #1;
        check("R9");
        tick(1'b0, 1'b0);
        check("R9");
        balance_i = 1'b0;
        #1;
        check("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scheme(2'b00, 1'b0, 500, "R2_R5");
        t_scheme(2'b01, 1'b0, 500, "R6");
        t_scheme(2'b10, 1'b0, 500, "R7");
        t_scheme(2'b11, 1'b0, 500, "R8");
        t_scheme(2'b00, 1'b1, 500, "R9_R5");
        t_scheme(2'b01, 1'b1, 500, "R9_R6");
        t_scheme(2'b10, 1'b1, 500, "R9_R7");
        t_hold();
        t_init();
        t_balance_switch();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule